// File: doc/BRIEF.md
# Scaled Offset-Binary DAC Loader

This block takes a signed 32-bit accumulated result, divides it by a power of two, and presents it to an external 16-bit bipolar converter. The converter has an 8-bit data port. A strobe is offered together with `sumValid`, and the block captures the value and the requested shift amount at that moment. It then shifts the value one bit per clock, keeping the sign. When the count is used up, it writes the low byte and then the high byte into the converter's input latch. A final pulse transfers the latch to the analog output.

The converter expects offset-binary code, so the top bit of the written word reflects the sign of the complete 32-bit value rather than bit 15 of the shifted result. After reset the block runs the same write sequence on a cleared value, which puts mid-scale (zero volts) on the converter. If a new value arrives while a shift or a write is under way, the block drops the work in progress and starts again on the new value.

Top module: `scaled_dac_loader`

## Requirements
- R1: While reset is asserted, `dacCsN` is high and `dacLoad` is low. After reset is released, the block writes 0x8000 to the converter and then leaves `busy` low.
- R2: On a clock where `sumValid` is high, the block captures `sumIn` and `shiftAmt` (0 to 15). The value written is `sumIn` arithmetically shifted right by `shiftAmt`, with the sign replicated.
- R3: Bits 14:0 of the written word are bits 14:0 of the shifted value. Bit 15 is 1 when the 32-bit value is non-negative and 0 when it is negative.
- R4: The low byte (word bits 7:0) is written first with `dacByteHi`=0. The high byte (bits 15:8) is written next with `dacByteHi`=1. Each byte is presented on `dacData` and latched by a one-cycle low pulse on `dacCsN`, and `dacByteHi` is held steady through the pulse.
- R5: One cycle after the high-byte strobe, `dacLoad` pulses high for one cycle. On the following cycle `dacByteHi` is back to 0.
- R6: A `sumValid` during a shift or a write abandons that work and restarts from the new value with the new shift amount. No load pulse is produced for the abandoned value.
- R7: The write starts only after the full shift count has elapsed. `busy` stays high for exactly `shiftAmt`+5 cycles after the capture, and each capture that is not interrupted gives exactly one load pulse.
- R8: Changes on `shiftAmt` while `sumValid` is low have no effect on the value being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sumIn | input | 32 | Signed value to scale and output |
| sumValid | input | 1 | Captures `sumIn` and `shiftAmt` |
| shiftAmt | input | 4 | Right-shift amount, 0 to 15 |
| dacData | output | 8 | Byte presented to the converter |
| dacByteHi | output | 1 | 0 selects the low latch byte, 1 the high |
| dacCsN | output | 1 | Active-low byte latch strobe |
| dacLoad | output | 1 | Transfers the 16-bit latch to the output |
| busy | output | 1 | High while shifting or writing |

## Verification
The critical overlap is a new `sumValid` that arrives while the block is already busy: either during shifting, or during the byte strobes of a write. The bench places a second capture a few cycles into a long shift. It also places one right after the low-byte strobe of a zero-shift write. Correct behaviour is judged with a behavioural converter model in the bench: exactly one extra load pulse, a converter output equal to the second value's expected code, and the low-then-high strobe order kept on the completed write.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  typedef struct packed {
    logic loadSum;
    logic shiftOne;
    logic selHi;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SHIFT = 3'd1,
    ST_LOSET = 3'd2,
    ST_LOSTB = 3'd3,
    ST_HISET = 3'd4,
    ST_HISTB = 3'd5,
    ST_XFER  = 3'd6
  } ctlState_t;
endpackage

// File: rtl/dacld_ctrl.sv
module dacld_ctrl
  import dacld_pkg::*;
#(
  parameter int SH_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sumValid,
  input  logic [SH_W-1:0] shiftAmt,
  output dpStrobe_t       strb,
  output logic            dacByteHi,
  output logic            dacCsN,
  output logic            dacLoad,
  output logic            busy
);
  ctlState_t state, nxtState;
  logic [SH_W-1:0] shiftCnt;

  always_comb begin
    nxtState     = state;
    strb         = '0;
    strb.selHi   = (state == ST_HISET) || (state == ST_HISTB) || (state == ST_XFER);
    if (sumValid) begin
      strb.loadSum = 1'b1;
      nxtState     = (shiftAmt == '0) ? ST_LOSET : ST_SHIFT;
    end else begin
      unique case (state)
        ST_SHIFT: begin
          strb.shiftOne = 1'b1;
          if (shiftCnt == SH_W'(1)) nxtState = ST_LOSET;
        end
        ST_LOSET: nxtState = ST_LOSTB;
        ST_LOSTB: nxtState = ST_HISET;
        ST_HISET: nxtState = ST_HISTB;
        ST_HISTB: nxtState = ST_XFER;
        ST_XFER:  nxtState = ST_IDLE;
        default:  nxtState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_LOSET;
      shiftCnt <= '0;
    end else begin
      state <= nxtState;
      if (sumValid)               shiftCnt <= shiftAmt;
      else if (state == ST_SHIFT) shiftCnt <= shiftCnt - SH_W'(1);
    end
  end

  assign dacCsN    = !((state == ST_LOSTB) || (state == ST_HISTB));
  assign dacByteHi = strb.selHi;
  assign dacLoad   = (state == ST_XFER);
  assign busy      = (state != ST_IDLE);

  // R4: byte select may not move while the strobe is low
  p_sel_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    !dacCsN |-> $stable(dacByteHi));
  // R5: transfer only right after a high-byte strobe
  p_load_after_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    dacLoad |-> ($past(!dacCsN) && $past(dacByteHi)));
  // R5: transfer is a single cycle and returns to the low byte
  p_load_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    dacLoad |=> (!dacLoad && !dacByteHi));
  // R7: no strobe or transfer before the shift count is used up
  p_write_after_shift_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!dacCsN || dacLoad) |-> (shiftCnt == '0));
  // R7: shifting state always has work left
  p_shift_nonzero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (shiftCnt != '0));
endmodule

// File: rtl/dacld_dp.sv
module dacld_dp
  import dacld_pkg::*;
#(
  parameter int SUM_W = 32,
  parameter int DAC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SUM_W-1:0] sumIn,
  input  dpStrobe_t        strb,
  output logic [DAC_W/2-1:0] dacData
);
  localparam int BYTE_W = DAC_W / 2;

  logic [SUM_W-1:0] acc;
  logic [DAC_W-1:0] word;

  always_ff @(posedge clk) begin
    if (!rstN)              acc <= '0;
    else if (strb.loadSum)  acc <= sumIn;
    else if (strb.shiftOne) acc <= {acc[SUM_W-1], acc[SUM_W-1:1]};
  end

  assign word    = {~acc[SUM_W-1], acc[DAC_W-2:0]};
  assign dacData = strb.selHi ? word[DAC_W-1:BYTE_W] : word[BYTE_W-1:0];

  // R2: a shift step keeps the sign of the value
  p_sign_kept_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftOne |=> (acc[SUM_W-1] == $past(acc[SUM_W-1])));
endmodule

// File: rtl/scaled_dac_loader.sv
module scaled_dac_loader
  import dacld_pkg::*;
#(
  parameter int SUM_W = 32,
  parameter int DAC_W = 16,
  parameter int SH_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SUM_W-1:0]   sumIn,
  input  logic               sumValid,
  input  logic [SH_W-1:0]    shiftAmt,
  output logic [DAC_W/2-1:0] dacData,
  output logic               dacByteHi,
  output logic               dacCsN,
  output logic               dacLoad,
  output logic               busy
);
  dpStrobe_t strb;

  dacld_ctrl #(.SH_W(SH_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sumValid(sumValid), .shiftAmt(shiftAmt),
    .strb(strb), .dacByteHi(dacByteHi), .dacCsN(dacCsN),
    .dacLoad(dacLoad), .busy(busy)
  );

  dacld_dp #(.SUM_W(SUM_W), .DAC_W(DAC_W)) dp_i (
    .clk(clk), .rstN(rstN), .sumIn(sumIn), .strb(strb), .dacData(dacData)
  );
endmodule

// File: tb/scaled_dac_loader_tb.sv
module scaled_dac_loader_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] sumIn = '0;
  logic        sumValid = 1'b0;
  logic [3:0]  shiftAmt = 4'd2;
  logic [7:0]  dacData;
  logic        dacByteHi, dacCsN, dacLoad, busy;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  scaled_dac_loader dut_i (
    .clk(clk), .rstN(rstN), .sumIn(sumIn), .sumValid(sumValid),
    .shiftAmt(shiftAmt), .dacData(dacData), .dacByteHi(dacByteHi),
    .dacCsN(dacCsN), .dacLoad(dacLoad), .busy(busy)
  );

  // behavioural converter model
  logic [7:0]  latLo = 8'h11, latHi = 8'h11;
  logic [15:0] dacOut = 16'h1111;
  int          nLoads = 0;
  logic        prevSel = 1'b1, lastSel = 1'b1;
  logic        orderOk = 1'b1;

  always @(negedge dacCsN) begin
    if (dacByteHi) latHi = dacData; else latLo = dacData;
    prevSel = lastSel;
    lastSel = dacByteHi;
  end

  always @(posedge dacLoad) begin
    dacOut = {latHi, latLo};
    nLoads++;
    if (!(prevSel == 1'b0 && lastSel == 1'b1)) orderOk = 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expCode(input logic [31:0] s, input logic [3:0] sh);
    logic [31:0] v;
    v = $unsigned($signed(s) >>> sh);
    return {~s[31], v[14:0]};
  endfunction

  task automatic sendSum(input logic [31:0] s, input logic [3:0] sh);
    @(negedge clk);
    sumIn = s; shiftAmt = sh; sumValid = 1'b1;
    @(negedge clk);
    sumValid = 1'b0;
  endtask

  task automatic waitIdle(output int busyCycles);
    busyCycles = 0;
    while (busy && busyCycles < 1000) begin
      busyCycles++;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [31:0] sum;
    logic [3:0]  sh;
    logic [15:0] code;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1234, 4'd2,  16'h848D},
    '{32'hFFFF_0000, 4'd0,  16'h0000},
    '{32'h7FFF_FFFF, 4'd15, 16'hFFFF},
    '{32'h8000_0000, 4'd15, 16'h0000},
    '{32'hFFFF_7FFE, 4'd1,  16'h3FFF},
    '{32'h0000_8000, 4'd0,  16'h8000},
    '{32'hFFFF_FFF0, 4'd3,  16'h7FFE}
  };

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    int bc, loadsBefore;
    repeat (3) @(negedge clk);
    check("R1 csN in reset", {31'd0, dacCsN}, 32'd1);
    check("R1 load in reset", {31'd0, dacLoad}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    waitIdle(bc);
    check("R1 reset code", {16'd0, dacOut}, 32'h8000);
    check("R1 reset loads", nLoads, 1);
    check("R1 busy low", {31'd0, busy}, 32'd0);

    // table walk (R2, R3, R4, R5, R7)
    for (int i = 0; i < NV; i++) begin
      loadsBefore = nLoads;
      orderOk = 1'b1;
      sendSum(VECS[i].sum, VECS[i].sh);
      waitIdle(bc);
      check("R2 R3 code", {16'd0, dacOut}, {16'd0, VECS[i].code});
      check("R3 vs model", {16'd0, dacOut}, {16'd0, expCode(VECS[i].sum, VECS[i].sh)});
      check("R7 busy length", bc, VECS[i].sh + 5);
      check("R7 one load", nLoads - loadsBefore, 1);
      check("R4 byte order", {31'd0, orderOk}, 32'd1);
      check("R5 sel low after", {31'd0, dacByteHi}, 32'd0);
    end

    // R8: shiftAmt moved while shifting
    loadsBefore = nLoads;
    sendSum(32'h0001_0000, 4'd4);
    shiftAmt = 4'd0;
    @(negedge clk);
    shiftAmt = 4'd15;
    waitIdle(bc);
    check("R8 shift unchanged", {16'd0, dacOut}, {16'd0, expCode(32'h0001_0000, 4'd4)});
    check("R8 busy length", bc, 8);

    // R6: restart during shift
    loadsBefore = nLoads;
    sendSum(32'h1234_5678, 4'd15);
    repeat (4) @(negedge clk);
    sendSum(32'hF000_0123, 4'd2);
    waitIdle(bc);
    check("R6 restart shift code", {16'd0, dacOut}, {16'd0, expCode(32'hF000_0123, 4'd2)});
    check("R6 restart shift loads", nLoads - loadsBefore, 1);

    // R6: restart right after the low-byte strobe of a zero-shift write
    loadsBefore = nLoads;
    orderOk = 1'b1;
    sendSum(32'h0000_7F7F, 4'd0);
    @(negedge clk);
    sumIn = 32'hFFFF_FF00; shiftAmt = 4'd3; sumValid = 1'b1;
    @(negedge clk);
    sumValid = 1'b0;
    waitIdle(bc);
    check("R6 restart write code", {16'd0, dacOut}, {16'd0, expCode(32'hFFFF_FF00, 4'd3)});
    check("R6 restart write loads", nLoads - loadsBefore, 1);
    check("R4 order after restart", {31'd0, orderOk}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule